// File: doc/BRIEF.md
# Clock Synthesizer Auto-Relock Controller

This controller supervises one clock-synthesis unit, such as a delay-locked or phase-locked loop. It watches the unit's lock flag and a vector of failure status bits. When a failure is detected, it drives a reset pulse into the unit and then waits a bounded time for lock to return. If lock does not return in that time, it waits a quiet gap and tries again, with no limit on the number of attempts. A single edge-triggered pulse is not enough, because the pulse can end before the unit's input clock is back.

The "clock lost" status bits are not trusted on their own, because a floating input can pick up a neighbouring clock. Recovery therefore requires the lock flag to be high with every status bit clear. A "clock good" flag is raised only after that healthy condition has held for a qualification run. A saturating attempt counter is provided for diagnostics. The block is small so that it can be instantiated once per clock unit.

Top module: `clk_relock_ctrl`

## Requirements
- R1: The lock and status inputs each pass through two flip-flops before they are used. A change on them is applied at the third rising clock edge after it is driven, and never earlier.
- R2: A failure seen in the running state raises `unit_rst` at the next edge. A failure is the synchronized lock low, or any synchronized status bit high. `unit_rst` then stays high for exactly `PULSE_W` cycles.
- R3: After a pulse, the controller waits up to `LOCK_TO` cycles. If it sees synchronized lock high with all status bits clear, it returns to running with no further pulse.
- R4: If the wait times out, `unit_rst` stays low for a further gap of `LOCK_TO` cycles and then pulses again. With no lock, `unit_rst` is low for exactly 2×`LOCK_TO` cycles between pulses, and this repeats without end.
- R5: Lock high is not sufficient for recovery. While any status bit is held high, the controller keeps retrying and `clk_good` stays low.
- R6: `clk_good` rises only after `GOOD_RUN` consecutive edges in the running state with a healthy synchronized condition. It falls at the edge where a failure is detected, and it is never high while `unit_rst` is high.
- R7: `retry_cnt` increases by one each time a new pulse starts after a gap. It never changes by more than one per cycle, saturates at 2^`RETRY_W`−1 (255 by default), and is cleared only by reset.
- R8: While `rst_n` is low, `unit_rst`, `clk_good` and `retry_cnt` are all zero. After release, the unit is treated as unlocked, so a reset pulse is issued at the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_in | input | 1 | Lock flag from the clock unit (asynchronous) |
| stat_in | input | NSTAT | Failure status bits from the clock unit (asynchronous) |
| unit_rst | output | 1 | Reset to the clock unit, active high |
| clk_good | output | 1 | Qualified healthy-clock flag |
| retry_cnt | output | RETRY_W | Saturating count of retry pulses |

## Verification
The hardest situation to reach is one where lock is present but a status bit stays stuck high. This is the noise case the controller must not trust. The bench's stand-in unit returns lock normally while the bench holds one status bit high, and it checks that retries continue and `clk_good` never rises. A second hard case is the saturation of the attempt counter. Reaching it needs more than 255 full pulse, wait and gap cycles, so the bench uses a short lock timeout and leaves the input clock absent for about eleven thousand cycles. Random clock dropouts, lock delays that straddle the timeout, and short status glitches are compared cycle by cycle with a reference model computed in the bench.

// File: rtl/relock_pkg.sv
// Package: shared types for the auto-relock controller.
// Assumes: nothing beyond IEEE 1800-2017.
package relock_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PULSE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GAP   = 2'd3
    } relock_state_t;
endpackage

// File: rtl/relock_sync.sv
// Module: relock_sync
// Two-stage synchronizer, one chain per bit, for slow level signals.
// Assumes: inputs are quasi-static levels; no multi-bit coherency needed.
module relock_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stage1;
        logic stage2;
        // Two-flop chain for bit i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= d[i];
                stage2 <= stage1;
            end
        end
        assign q[i] = stage2;
    end
endmodule

// File: rtl/relock_fsm.sv
// Module: relock_fsm
// Recovery sequencer: run, pulse the unit reset, wait for lock, gap, retry.
// Assumes: healthy is already synchronized; PULSE_W >= 3; LOCK_TO >= 2.
module relock_fsm
    import relock_pkg::*;
#(
    parameter int PULSE_W = 4,
    parameter int LOCK_TO = 1024,
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               healthy,
    output relock_state_t      state,
    output logic               unit_rst,
    output logic [RETRY_W-1:0] retries
);
    localparam int SPAN = (LOCK_TO > PULSE_W) ? LOCK_TO : PULSE_W;
    localparam int TW   = $clog2(SPAN);
    localparam logic [TW-1:0]      PULSE_LAST = TW'(PULSE_W - 1);
    localparam logic [TW-1:0]      WAIT_LAST  = TW'(LOCK_TO - 1);
    localparam logic [RETRY_W-1:0] RETRY_MAX  = '1;

    logic [TW-1:0] timer;

    // State, interval timer and retry counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_RUN;
            timer   <= '0;
            retries <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (!healthy) begin
                        state <= ST_PULSE;
                        timer <= '0;
                    end
                end
                ST_PULSE: begin
                    if (timer == PULSE_LAST) begin
                        state <= ST_WAIT;
                        timer <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (healthy) begin
                        state <= ST_RUN;
                    end else if (timer == WAIT_LAST) begin
                        state <= ST_GAP;
                        timer <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (healthy) begin
                        state <= ST_RUN;
                    end else if (timer == WAIT_LAST) begin
                        state <= ST_PULSE;
                        timer <= '0;
                        if (retries != RETRY_MAX) retries <= retries + 1'b1;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Reset output decoded from the registered state.
    assign unit_rst = (state == ST_PULSE);

    // R2: the pulse keeps going until its last cycle, then ends.
    p_pulse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_rst && timer != PULSE_LAST) |=> unit_rst);
    p_pulse_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_rst && timer == PULSE_LAST) |=> !unit_rst);
    // R3: healthy while waiting returns to running.
    p_recover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && healthy) |=> state == ST_RUN);
    // R4: wait timeout leads to the quiet gap.
    p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !healthy && timer == WAIT_LAST) |=> state == ST_GAP);
    // R7: counter steps by one at most and holds at saturation.
    p_retry_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retries != $past(retries)) |-> (retries == $past(retries) + 1'b1));
    p_retry_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retries == RETRY_MAX) |=> (retries == RETRY_MAX));
endmodule

// File: rtl/relock_qual.sv
// Module: relock_qual
// Qualifies the clock-good flag over a run of consecutive healthy cycles.
// Assumes: GOOD_RUN >= 2; ok_run is registered-source logic in this domain.
module relock_qual #(
    parameter int GOOD_RUN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_run,
    output logic good
);
    localparam int QW = $clog2(GOOD_RUN);
    localparam logic [QW-1:0] RUN_LAST = QW'(GOOD_RUN - 1);

    logic [QW-1:0] run_len;

    // Count healthy cycles; any break clears both count and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            good    <= 1'b0;
        end else if (!ok_run) begin
            run_len <= '0;
            good    <= 1'b0;
        end else if (run_len == RUN_LAST) begin
            good <= 1'b1;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    // R6: a break in the healthy run always clears the flag.
    p_break_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_run |=> !good);
    // R6: the flag can only rise after a healthy cycle.
    p_rise_healthy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(good) |-> $past(ok_run));
endmodule

// File: rtl/clk_relock_ctrl.sv
// Module: clk_relock_ctrl (top)
// Auto-relock supervisor for one clock-synthesis unit: synchronizes its
// status, retries resets until lock returns, qualifies a clock-good flag.
// Assumes: lock_in and stat_in are asynchronous levels; clk is free-running.
module clk_relock_ctrl
    import relock_pkg::*;
#(
    parameter int NSTAT    = 4,
    parameter int PULSE_W  = 4,
    parameter int LOCK_TO  = 1024,
    parameter int GOOD_RUN = 16,
    parameter int RETRY_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_in,
    input  logic [NSTAT-1:0]   stat_in,
    output logic               unit_rst,
    output logic               clk_good,
    output logic [RETRY_W-1:0] retry_cnt
);
    localparam int SW = NSTAT + 1;

    logic [SW-1:0] raw_vec;
    logic [SW-1:0] sync_vec;
    logic          lock_s;
    logic          fail_s;
    logic          healthy;
    relock_state_t state;

    assign raw_vec = {stat_in, lock_in};

    relock_sync #(.WIDTH(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (sync_vec)
    );

    // Lock flag alone is not trusted: any status bit vetoes health.
    assign lock_s  = sync_vec[0];
    assign fail_s  = |sync_vec[SW-1:1];
    assign healthy = lock_s && !fail_s;

    relock_fsm #(
        .PULSE_W (PULSE_W),
        .LOCK_TO (LOCK_TO),
        .RETRY_W (RETRY_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .healthy  (healthy),
        .state    (state),
        .unit_rst (unit_rst),
        .retries  (retry_cnt)
    );

    relock_qual #(.GOOD_RUN(GOOD_RUN)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .ok_run (state == ST_RUN && healthy),
        .good   (clk_good)
    );

    // R6: never report a good clock while resetting the unit.
    p_good_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unit_rst |-> !clk_good);
    // R5 / R6: a status bit seen while good drops the flag next cycle.
    p_stat_drops_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_good && fail_s) |=> !clk_good);
    // R2: a detected failure while running starts the pulse.
    p_fail_pulses_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !healthy) |=> unit_rst);
endmodule

// File: tb/clk_relock_ctrl_test.sv
module clk_relock_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int PW = 3;
    localparam int LT = 20;
    localparam int GR = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_in = 1'b0;
    logic [NS-1:0] stat_force = '0;
    logic          uut_rst;
    logic          clk_good;
    logic [7:0]    retry_cnt;

    int checks = 0;
    int fails = 0;

    // Stand-in clock unit controls.
    logic src_on = 1'b1;
    int   lk_dly = 5;
    int   cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_relock_ctrl #(
        .NSTAT(NS), .PULSE_W(PW), .LOCK_TO(LT), .GOOD_RUN(GR), .RETRY_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .stat_in(stat_force),
        .unit_rst(uut_rst), .clk_good(clk_good), .retry_cnt(retry_cnt)
    );

    // Behavioural clock unit: lock drops in reset or without input clock.
    always @(negedge clk) begin
        if (!rst_n || uut_rst || !src_on) begin
            lock_in <= 1'b0;
            cnt <= 0;
        end else if (cnt >= lk_dly) begin
            lock_in <= 1'b1;
        end else begin
            cnt <= cnt + 1;
        end
    end

    // Reference model written from the requirements.
    logic ml1, ml2, mf1, mf2, mg;
    int   ms, mt, mr, mq;
    bit   mok;
    always @(posedge clk) begin
        if (!rst_n) begin
            ml1 <= 0; ml2 <= 0; mf1 <= 0; mf2 <= 0; mg <= 0;
            ms <= 0; mt <= 0; mr <= 0; mq <= 0;
        end else begin
            ml1 <= lock_in; ml2 <= ml1;
            mf1 <= |stat_force; mf2 <= mf1;
            mok = ml2 && !mf2;
            case (ms)
                0: if (!mok) begin ms <= 1; mt <= 0; end
                1: if (mt == PW-1) begin ms <= 2; mt <= 0; end else mt <= mt + 1;
                2: if (mok) ms <= 0;
                   else if (mt == LT-1) begin ms <= 3; mt <= 0; end
                   else mt <= mt + 1;
                default: if (mok) ms <= 0;
                   else if (mt == LT-1) begin
                       ms <= 1; mt <= 0;
                       if (mr < 255) mr <= mr + 1;
                   end else mt <= mt + 1;
            endcase
            if (ms == 0 && mok) begin
                if (mq == GR-1) mg <= 1; else mq <= mq + 1;
            end else begin
                mq <= 0; mg <= 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Per-cycle comparison against the model.
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            check("R2 unit_rst vs model", int'(uut_rst), int'(ms == 1));
            check("R6 clk_good vs model", int'(clk_good), int'(mg));
            check("R7 retry_cnt vs model", int'(retry_cnt), mr);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int r0;
        bit seen;
        void'($urandom(32'd2024));
        repeat (3) tick();
        // R8: outputs idle in reset.
        check("R8 unit_rst in reset", int'(uut_rst), 0);
        check("R8 clk_good in reset", int'(clk_good), 0);
        check("R8 retry_cnt in reset", int'(retry_cnt), 0);
        rst_n = 1'b1;
        tick();
        check("R8 startup pulse", int'(uut_rst), 1);
        // R2: pulse width.
        n = 0;
        while (uut_rst && n < 50) begin n++; tick(); end
        check("R2 pulse width", n, PW);
        // R6: qualification latency (2 sync + 1 transition + GR).
        while (!lock_in) tick();
        n = 0;
        while (!clk_good && n < 100) begin tick(); n++; end
        check("R6 good latency", n, 3 + GR);
        check("R3 no retry on quick lock", int'(retry_cnt), 0);
        // R1: status bit takes effect at the third edge.
        stat_force = 4'b0010;
        tick();
        check("R1 no effect after 1 edge", int'(uut_rst), 0);
        tick();
        check("R1 no effect after 2 edges", int'(uut_rst), 0);
        check("R1 good held after 2 edges", int'(clk_good), 1);
        tick();
        check("R1 pulse at 3rd edge", int'(uut_rst), 1);
        check("R6 good dropped", int'(clk_good), 0);
        stat_force = '0;
        n = 0;
        while (!clk_good && n < 200) begin tick(); n++; end
        check("R3 relock after status clears", int'(clk_good), 1);
        // R4: gap length and retry increment with no input clock.
        src_on = 1'b0;
        while (!uut_rst) tick();
        while (uut_rst) tick();
        r0 = int'(retry_cnt);
        n = 0;
        while (!uut_rst && n < 200) begin tick(); n++; end
        check("R4 low time between pulses", n, 2*LT);
        check("R7 retry increment", int'(retry_cnt), r0 + 1);
        // R5: lock present but a status bit stuck high.
        r0 = int'(retry_cnt);
        src_on = 1'b1;
        stat_force = 4'b1000;
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            tick();
            if (clk_good) seen = 1;
        end
        check("R5 no good with stuck status", int'(seen), 0);
        check("R5 retries continue", int'(retry_cnt > 8'(r0)), 1);
        stat_force = '0;
        n = 0;
        while (!clk_good && n < 200) begin tick(); n++; end
        check("R3 recovery after noise", int'(clk_good), 1);
        // Random phase: dropouts, lock delays across the timeout, glitches.
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 3) src_on = !src_on;
            else if (r < 6) lk_dly = int'($urandom % 45);
            stat_force = (r >= 96) ? NS'(1 << ($urandom % NS)) : '0;
            tick();
        end
        stat_force = '0;
        // R7: saturation.
        src_on = 1'b0;
        n = 0;
        while (retry_cnt != 8'd255 && n < 14000) begin tick(); n++; end
        repeat (120) tick();
        check("R7 saturated", int'(retry_cnt), 255);
        // R8: reset clears everything.
        rst_n = 1'b0;
        tick();
        tick();
        check("R8 retry cleared", int'(retry_cnt), 0);
        check("R8 pulse cleared", int'(uut_rst), 0);
        check("R8 good cleared", int'(clk_good), 0);
        rst_n = 1'b1;
        repeat (5) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule